// File: doc/BRIEF.md
# SMBus Configuration Slave

This block lets an external SMBus host read and write the hub's byte-wide configuration register file. It answers only the block write and block read protocols, at a 7-bit address whose two low bits come from strap inputs captured while reset is held. SCL and SDA are brought into the system clock domain through a two-flop synchroniser. Start, stop and clock edges are found from the synchronised copies. The block drives SDA through an open-drain enable.

A status/command byte at offset F8h holds two control bits. Bit 0 is a configuration-active flag that keeps the upstream connection disabled until the host writes 1 to it. Bit 1 is a soft reset: writing 1 to it restores every register, re-arms the flag and then clears itself. Port description fields are protected by a custom-enable bit, and reserved bits keep fixed values. The whole register file is presented as a flat bus to the logic that uses it.

Top module: `smbus_cfg_slave`

## Requirements
- R1: The slave ACKs an address byte only when its upper seven bits equal 1,0,0,0,1,strap_a1,strap_a0, with both straps taken while rst_n is low. Any other address is NACKed.
- R2: In a block write, the byte after the address is the start offset and the next byte is a count. The data bytes then go to consecutive offsets. A count above MAX_BLK (32) is NACKed and nothing is written. A data byte beyond the count is NACKed and not written.
- R3: In a block read (address+W, offset, repeated start, address+R), the slave first sends the count RD_LEN (4). It then sends that many bytes from consecutive offsets starting at the given offset.
- R4: An address+R that directly follows a fresh start, with no offset byte earlier in the same transaction, is NACKed.
- R5: After reset, cfg_active is 1 and hub_connect_en is 0. hub_connect_en is 1 exactly while cfg_active is 0.
- R6: Writing a byte with bit 0 set to offset F8h clears cfg_active, and writing 0 has no effect. Reading F8h returns {6'b0, soft-reset pending, cfg_active}.
- R7: Writing a byte with bit 1 set to offset F8h restores every register to its reset value (05h=10h, 08h=0Fh, all others 00h) and sets cfg_active to 1. The bit reads back 0 afterwards.
- R8: Bits 3:0 of offsets 07h, 08h and 26h can be written only while bit 7 of 07h is 1. A single write to 07h may set bit 7 and bits 3:0 together.
- R9: Reserved bits are fixed. In 05h, bit 4 reads 1 and bit 0 reads 0. Bits 7:4 of 06h read 0. Offsets 09h and 0Ch–0Fh read 00h.
- R10: Bit 4 of 0Ah can be written only when the same byte sets bit 6. Bits 7 and 0 of 0Ah read 0.
- R11: An offset at or above NREG (30h), other than F8h, reads 00h and ignores writes, but the byte is still ACKed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset; the straps are sampled while it is low |
| scl_in | input | 1 | SMBus clock as seen on the bus |
| sda_in | input | 1 | SMBus data as seen on the bus |
| strap_a1 | input | 1 | Address strap, address bit 1 |
| strap_a0 | input | 1 | Address strap, address bit 0 |
| sda_oe | output | 1 | Pulls SDA low when 1 (open drain) |
| cfg_active | output | 1 | Configuration in progress |
| hub_connect_en | output | 1 | Upstream connection allowed |
| cfg_regs | output | 8*NREG | Register file, offset n at bits 8n+7:8n |

## Verification
The assertions assume a well-behaved bus master. SDA changes only while SCL is low, except for the start and stop conditions. Every SCL level lasts well beyond the synchroniser delay. Under these conditions the open-drain enable of the slave changes only while the synchronised SCL is low. The bench master follows both rules: it waits five system clocks after each SCL edge before it moves SDA, and it keeps each SCL high phase ten clocks long.

// File: rtl/smbus_cfg_slave.sv
module smbus_cfg_slave #(
  parameter int NREG = 48,
  parameter int MAX_BLK = 32,
  parameter int RD_LEN = 4,
  parameter logic [4:0] ADDR_HI = 5'b10001,
  parameter logic [7:0] CMD_OFS = 8'hF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              strap_a1,
  input  logic              strap_a0,
  output logic              sda_oe,
  output logic              cfg_active,
  output logic              hub_connect_en,
  output logic [8*NREG-1:0] cfg_regs
);
  localparam int AW = $clog2(NREG);
  localparam int CW = $clog2(MAX_BLK + 1);
  localparam logic [7:0] NREG8 = 8'(NREG);

  typedef enum logic [2:0] {P_IDLE, P_RX, P_RXACK, P_TX, P_TXACK} phase_t;
  typedef enum logic [2:0] {S_ADDR, S_CMD, S_WCNT, S_WDATA, S_RDATA} step_t;

  phase_t phase;
  step_t  step;
  logic [2:0] scl_q, sda_q;
  logic [1:0] strap_q;
  logic [3:0] bitcnt;
  logic [7:0] shreg, ptr, rd_data;
  logic [CW-1:0] cnt;
  logic have_cmd, srst_pend;
  logic [7:0] regs [NREG];

  function automatic logic [7:0] rst_val(input int i);
    case (i)
      5:       return 8'h10;
      8:       return 8'h0F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] wmask(input logic [7:0] a, input logic [7:0] d, input logic cust);
    case (a)
      8'h05:                      return 8'hEE;
      8'h06:                      return 8'h0F;
      8'h07:                      return {1'b1, 3'b000, {4{d[7]}}};
      8'h08, 8'h26:               return {4'h0, {4{cust}}};
      8'h09, 8'h0C, 8'h0D,
      8'h0E, 8'h0F:               return 8'h00;
      8'h0A:                      return {3'b011, d[6], 3'b111, 1'b0};
      default:                    return 8'hFF;
    endcase
  endfunction

  logic scl_s, scl_p, sda_s, sda_p;
  assign scl_s = scl_q[1];
  assign scl_p = scl_q[2];
  assign sda_s = sda_q[1];
  assign sda_p = sda_q[2];

  logic scl_rise, scl_fall, start_ev, stop_ev, byte_done, addr_hit, wr_en;
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_ev  = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev   = scl_s & scl_p & ~sda_p & sda_s;
  assign byte_done = (phase == P_RX) && scl_fall && (bitcnt == 4'd8);
  assign addr_hit  = shreg[7:1] == {ADDR_HI, strap_q};
  assign wr_en     = byte_done && (step == S_WDATA) && (cnt != '0);

  assign hub_connect_en = ~cfg_active;

  always_comb begin
    if (ptr < NREG8)        rd_data = regs[ptr[AW-1:0]];
    else if (ptr == CMD_OFS) rd_data = {6'b0, srst_pend, cfg_active};
    else                    rd_data = 8'h00;
  end

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_flat
      assign cfg_regs[8*g +: 8] = regs[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q   <= 3'b111;
      sda_q   <= 3'b111;
      strap_q <= {strap_a1, strap_a0};
    end else begin
      scl_q <= {scl_q[1:0], scl_in};
      sda_q <= {sda_q[1:0], sda_in};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || srst_pend) begin
      for (int i = 0; i < NREG; i++) regs[i] <= rst_val(i);
    end else if (wr_en && ptr < NREG8) begin
      regs[ptr[AW-1:0]] <= (regs[ptr[AW-1:0]] & ~wmask(ptr, shreg, regs[7][7]))
                         | (shreg & wmask(ptr, shreg, regs[7][7]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_active <= 1'b1;
      srst_pend  <= 1'b0;
    end else if (srst_pend) begin
      cfg_active <= 1'b1;
      srst_pend  <= 1'b0;
    end else if (wr_en && ptr == CMD_OFS) begin
      if (shreg[1])      srst_pend  <= 1'b1;
      else if (shreg[0]) cfg_active <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= P_IDLE;
      step     <= S_ADDR;
      bitcnt   <= '0;
      shreg    <= '0;
      ptr      <= '0;
      cnt      <= '0;
      have_cmd <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (stop_ev) begin
      phase    <= P_IDLE;
      have_cmd <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (start_ev) begin
      phase  <= P_RX;
      step   <= S_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else begin
      case (phase)
        P_RX: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_done) begin
            case (step)
              S_ADDR: begin
                if (addr_hit && !shreg[0]) begin
                  step <= S_CMD; phase <= P_RXACK; sda_oe <= 1'b1;
                end else if (addr_hit && have_cmd) begin
                  step <= S_RDATA; cnt <= CW'(RD_LEN); shreg <= 8'(RD_LEN);
                  phase <= P_RXACK; sda_oe <= 1'b1;
                end else phase <= P_IDLE;
              end
              S_CMD: begin
                ptr <= shreg; have_cmd <= 1'b1; step <= S_WCNT;
                phase <= P_RXACK; sda_oe <= 1'b1;
              end
              S_WCNT: begin
                if (shreg <= 8'(MAX_BLK)) begin
                  cnt <= shreg[CW-1:0]; step <= S_WDATA;
                  phase <= P_RXACK; sda_oe <= 1'b1;
                end else phase <= P_IDLE;
              end
              S_WDATA: begin
                if (cnt != '0) begin
                  ptr <= ptr + 8'd1; cnt <= cnt - 1'b1;
                  phase <= P_RXACK; sda_oe <= 1'b1;
                end else phase <= P_IDLE;
              end
              default: phase <= P_IDLE;
            endcase
          end
        end
        P_RXACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (step == S_RDATA) begin
              phase <= P_TX; sda_oe <= ~shreg[7];
            end else begin
              phase <= P_RX; sda_oe <= 1'b0;
            end
          end
        end
        P_TX: begin
          if (scl_rise) bitcnt <= bitcnt + 4'd1;
          else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0; phase <= P_TXACK;
            end else begin
              shreg <= {shreg[6:0], 1'b0}; sda_oe <= ~shreg[6];
            end
          end
        end
        P_TXACK: begin
          if (scl_rise) begin
            if (sda_s || cnt == '0) phase <= P_IDLE;
            else begin
              shreg <= rd_data; ptr <= ptr + 8'd1; cnt <= cnt - 1'b1;
            end
          end else if (scl_fall) begin
            phase <= P_TX; bitcnt <= '0; sda_oe <= ~shreg[7];
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/smbus_cfg_slave_chk.sv
module smbus_cfg_slave_chk #(
  parameter int NREG = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              sda_oe,
  input logic              cfg_active,
  input logic              srst_pend,
  input logic [8*NREG-1:0] cfg_regs
);
  assert_cfg_after_reset_R5: assert property (@(posedge clk)
    $rose(rst_n) |-> cfg_active);

  assert_cfg_rearm_only_by_srst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_active) |-> $past(srst_pend));

  assert_srst_self_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    srst_pend |=> !srst_pend);

  assert_sda_moves_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  assert_rsvd_bits_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_regs[8*5+4] && !cfg_regs[8*5] && (cfg_regs[8*6+4 +: 4] == 4'h0));

  assert_used_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_regs[8*7+7] && !$past(cfg_regs[8*7+7]) && !$past(srst_pend))
      |-> $stable(cfg_regs[8*8 +: 4]));
endmodule

bind smbus_cfg_slave smbus_cfg_slave_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .cfg_active(cfg_active), .srst_pend(srst_pend), .cfg_regs(cfg_regs));

// File: tb/test_smbus_cfg_slave.sv
module test_smbus_cfg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = 5 * CLK_PERIOD;
  localparam int HALF = 2 * QTR;
  localparam logic [6:0] DEV = 7'b1000110;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, cfg_active, hub_connect_en, sda_bus;
  logic [8*48-1:0] cfg_regs;
  logic [7:0] wbuf [0:7];
  logic [7:0] rbuf [0:7];
  int checks = 0, errors = 0;

  assign sda_bus = sda_m & ~sda_oe;
  always #(CLK_PERIOD/2) clk = ~clk;

  smbus_cfg_slave i_smbus_cfg_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus),
    .strap_a1(1'b1), .strap_a0(1'b0), .sda_oe(sda_oe),
    .cfg_active(cfg_active), .hub_connect_en(hub_connect_en), .cfg_regs(cfg_regs));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rb(input int off);
    return cfg_regs[8*off +: 8];
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; scl = 1'b1; #QTR; sda_m = 1'b0; #QTR; scl = 1'b0; #QTR;
  endtask
  task automatic bus_rstart();
    sda_m = 1'b1; #QTR; scl = 1'b1; #QTR; sda_m = 1'b0; #QTR; scl = 1'b0; #QTR;
  endtask
  task automatic bus_stop();
    sda_m = 1'b0; #QTR; scl = 1'b1; #QTR; sda_m = 1'b1; #QTR;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; #QTR; scl = 1'b1; #HALF; scl = 1'b0; #QTR;
    end
    sda_m = 1'b1; #QTR; scl = 1'b1; #(HALF/2); ack = ~sda_bus; #(HALF/2); scl = 1'b0; #QTR;
  endtask

  task automatic recv_byte(input logic ack_it, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      #QTR; scl = 1'b1; #(HALF/2); b[i] = sda_bus; #(HALF/2); scl = 1'b0;
    end
    #QTR; sda_m = ~ack_it; #QTR; scl = 1'b1; #HALF; scl = 1'b0; #QTR; sda_m = 1'b1;
  endtask

  task automatic smb_write(input logic [6:0] dev, input logic [7:0] off, input logic [7:0] cnt,
                           input int nsend, output int acks);
    logic a;
    acks = 0;
    bus_start();
    send_byte({dev, 1'b0}, a);
    if (a) begin
      acks++; send_byte(off, a);
      if (a) begin
        acks++; send_byte(cnt, a);
        if (a) begin
          acks++;
          for (int i = 0; i < nsend; i++) begin
            send_byte(wbuf[i], a);
            if (!a) break;
            acks++;
          end
        end
      end
    end
    bus_stop();
  endtask

  task automatic smb_read(input logic [7:0] off, output int acks, output logic [7:0] cnt);
    logic a;
    acks = 0; cnt = 8'h00;
    bus_start();
    send_byte({DEV, 1'b0}, a); if (a) acks++;
    send_byte(off, a); if (a) acks++;
    bus_rstart();
    send_byte({DEV, 1'b1}, a);
    if (a) begin
      acks++;
      recv_byte(1'b1, cnt);
      for (int i = 0; i < 8 && i < int'(cnt); i++) recv_byte(i != int'(cnt) - 1, rbuf[i]);
    end
    bus_stop();
  endtask

  task automatic wr1(input logic [7:0] off, input logic [7:0] val);
    int acks;
    wbuf[0] = val;
    smb_write(DEV, off, 8'd1, 1, acks);
  endtask

  task automatic t_reset();
    chk("R5 cfg_active after reset", cfg_active, 1);
    chk("R5 hub_connect_en after reset", hub_connect_en, 0);
    chk("R7 reset value 05h", rb(5), 8'h10);
    chk("R7 reset value 08h", rb(8), 8'h0F);
    chk("R1 sda released at reset", sda_oe, 0);
  endtask

  task automatic t_address();
    int acks;
    wbuf[0] = 8'h99;
    smb_write(7'b1000111, 8'h10, 8'd1, 1, acks);
    chk("R1 wrong address NACKed", acks, 0);
    smb_write(7'b1000100, 8'h10, 8'd1, 1, acks);
    chk("R1 other strap value NACKed", acks, 0);
    chk("R1 no write from foreign address", rb(16), 8'h00);
  endtask

  task automatic t_write_read();
    int acks; logic [7:0] c;
    wbuf[0] = 8'hA5; wbuf[1] = 8'h5A; wbuf[2] = 8'h3C;
    smb_write(DEV, 8'h10, 8'd3, 3, acks);
    chk("R2 all write bytes ACKed", acks, 6);
    chk("R2 byte at 10h", rb(16), 8'hA5);
    chk("R2 byte at 12h", rb(18), 8'h3C);
    smb_read(8'h10, acks, c);
    chk("R3 read acks", acks, 3);
    chk("R3 read count", c, 4);
    chk("R3 read 10h", rbuf[0], 8'hA5);
    chk("R3 read 11h", rbuf[1], 8'h5A);
    chk("R3 read 12h", rbuf[2], 8'h3C);
    chk("R3 read 13h", rbuf[3], 8'h00);
  endtask

  task automatic t_count_limits();
    int acks;
    wbuf[0] = 8'hAA;
    smb_write(DEV, 8'h20, 8'd33, 1, acks);
    chk("R2 oversize count NACKed", acks, 2);
    chk("R2 oversize count writes nothing", rb(32), 8'h00);
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    smb_write(DEV, 8'h14, 8'd1, 2, acks);
    chk("R2 byte past count NACKed", acks, 4);
    chk("R2 counted byte written", rb(20), 8'h11);
    chk("R2 byte past count dropped", rb(21), 8'h00);
  endtask

  task automatic t_recv_byte();
    logic a;
    bus_start();
    send_byte({DEV, 1'b1}, a);
    bus_stop();
    chk("R4 read without offset NACKed", a, 0);
  endtask

  task automatic t_reserved();
    wr1(8'h05, 8'h00);
    chk("R9 05h bit4 stays set", rb(5), 8'h10);
    wr1(8'h05, 8'hFF);
    chk("R9 05h bit0 stays clear", rb(5), 8'hFE);
    wr1(8'h06, 8'hFF);
    chk("R9 06h upper nibble zero", rb(6), 8'h0F);
    wr1(8'h09, 8'hFF);
    chk("R9 09h reads zero", rb(9), 8'h00);
    wr1(8'h0D, 8'hFF);
    chk("R9 0Dh reads zero", rb(13), 8'h00);
  endtask

  task automatic t_hicur();
    wr1(8'h0A, 8'h10);
    chk("R10 bit4 blocked without bit6", rb(10), 8'h00);
    wr1(8'h0A, 8'h50);
    chk("R10 bit4 with bit6 in same byte", rb(10), 8'h50);
    wr1(8'h0A, 8'hFF);
    chk("R10 bits 7 and 0 fixed", rb(10), 8'h7E);
  endtask

  task automatic t_port_mask();
    wr1(8'h08, 8'h03);
    chk("R8 08h locked", rb(8), 8'h0F);
    wr1(8'h26, 8'h0A);
    chk("R8 26h locked", rb(38), 8'h00);
    wr1(8'h07, 8'h85);
    chk("R8 07h unlock and field in one write", rb(7), 8'h85);
    wr1(8'h08, 8'h03);
    chk("R8 08h writable when unlocked", rb(8), 8'h03);
    wr1(8'h26, 8'h0A);
    chk("R8 26h writable when unlocked", rb(38), 8'h0A);
  endtask

  task automatic t_out_range();
    int acks; logic [7:0] c;
    wbuf[0] = 8'h77;
    smb_write(DEV, 8'h40, 8'd1, 1, acks);
    chk("R11 out-of-range write ACKed", acks, 4);
    smb_read(8'h40, acks, c);
    chk("R11 out-of-range reads zero", rbuf[0], 8'h00);
    smb_read(8'h2E, acks, c);
    chk("R11 read crossing NREG", rbuf[2], 8'h00);
  endtask

  task automatic t_cfg_gate();
    int acks; logic [7:0] c;
    wr1(8'hF8, 8'h00);
    chk("R6 writing 0 keeps cfg_active", cfg_active, 1);
    chk("R5 connection held off", hub_connect_en, 0);
    wr1(8'hF8, 8'h01);
    chk("R6 writing 1 clears cfg_active", cfg_active, 0);
    chk("R5 connection allowed", hub_connect_en, 1);
    smb_read(8'hF8, acks, c);
    chk("R6 status byte read", rbuf[0], 8'h00);
  endtask

  task automatic t_soft_reset();
    int acks; logic [7:0] c;
    wr1(8'hF8, 8'h02);
    chk("R7 soft reset re-arms cfg_active", cfg_active, 1);
    chk("R7 soft reset clears 10h", rb(16), 8'h00);
    chk("R7 soft reset restores 07h", rb(7), 8'h00);
    chk("R7 soft reset restores 08h", rb(8), 8'h0F);
    chk("R7 soft reset restores 05h", rb(5), 8'h10);
    smb_read(8'hF8, acks, c);
    chk("R7 soft reset bit self clears", rbuf[0], 8'h01);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #(CLK_PERIOD/2);
    t_reset();
    t_address();
    t_write_read();
    t_count_limits();
    t_recv_byte();
    t_reserved();
    t_hicur();
    t_port_mask();
    t_out_range();
    t_cfg_gate();
    t_soft_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(150000 * CLK_PERIOD);
    errors++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule